// File: doc/BRIEF.md
# Three-Level Channel Priority Arbiter

This block decides which of four DMA channels may use the shared bus. Each channel raises a request line. Two configuration slots can each promote one named channel: one slot lifts its channel to the top level, and the other lifts its channel to the high level. Each slot has its own enable. Every channel that no enabled slot names stays at the normal level. Normal channels take turns in round-robin order.

A channel that wins keeps its grant for a configured budget of bus commands. The channel signals each command it issues with a strobe. When the budget runs out, the grant is released. It is also released at once if the holding channel withdraws its request. Arbitration runs only while no grant is held, so a grant never changes hands in the middle of a command. The grant is a registered one-hot vector.

Top module: `dma_prio_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the grant output is all zeros.
- R2: At most one grant bit is set. A grant bit is set only if that channel's request was high in the previous cycle.
- R3: While no grant is held, a channel named by the enabled top slot that is requesting receives the grant in the next cycle, ahead of all other channels.
- R4: While no grant is held and the top channel is not requesting, a requesting channel named by the enabled high slot receives the grant ahead of every normal channel.
- R5: If both slots are enabled and name the same channel, that channel is treated as top, and every other channel is normal.
- R6: A channel named only by a disabled slot competes at the normal level.
- R7: Normal channels are granted in round-robin order. The search starts at the channel after the last normal channel granted, with increasing index wrapping from 3 to 0. After reset, channel 0 is searched first.
- R8: A grant is held until the holding channel has issued the tokens value number of command strobes. The grant output reads zero in the cycle after the last strobe. A tokens value of 0 behaves as 1.
- R9: Command strobes from channels that do not hold the grant have no effect on the grant or on the token count.
- R10: If the holding channel drops its request, the grant goes to zero in the next cycle.
- R11: Once a grant is held, it cannot move to another channel in the following cycle. After a release, the grant is zero for at least one cycle before the next grant is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 4 | Per-channel bus request |
| cmd_issued | input | 4 | Per-channel strobe, one pulse per bus command issued |
| top_idx | input | 2 | Channel promoted to the top level |
| top_en | input | 1 | Enable for the top slot |
| high_idx | input | 2 | Channel promoted to the high level |
| high_en | input | 1 | Enable for the high slot |
| tokens | input | 8 | Command budget per grant (0 means 1) |
| grant | output | 4 | One-hot bus grant |

## Verification
The hardest case to reach is the round-robin pointer while promoted channels are also active. The pointer moves only on normal grants, so its position depends on the whole history of grants before it. The bench therefore runs a cycle-level model beside the design and compares every cycle. It sweeps every slot configuration against every request pattern, which carries the pointer through many starting positions. Token expiry is reached by feeding the grant back as the command strobe. Strobes from idle channels are driven in the same cycles to show they are ignored.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [1:0] {
    LVL_NORMAL = 2'd0,
    LVL_HIGH   = 2'd1,
    LVL_TOP    = 2'd2
  } prio_lvl_e;
endpackage

// File: rtl/arb_prio_classify.sv
module arb_prio_classify #(
  parameter int N_CH  = 4,
  localparam int IDX_W = $clog2(N_CH)
) (
  input  logic [N_CH-1:0]  req,
  input  logic [IDX_W-1:0] top_idx,
  input  logic             top_en,
  input  logic [IDX_W-1:0] high_idx,
  input  logic             high_en,
  output logic             top_hit,
  output logic             high_hit,
  output logic [N_CH-1:0]  norm_req
);
  import dma_arb_pkg::*;

  prio_lvl_e lvl [N_CH];

  generate
    for (genvar i = 0; i < N_CH; i++) begin : g_lvl
      always_comb begin
        if (top_en && (top_idx == IDX_W'(i)))
          lvl[i] = LVL_TOP;
        else if (high_en && (high_idx == IDX_W'(i)))
          lvl[i] = LVL_HIGH;
        else
          lvl[i] = LVL_NORMAL;
      end
      assign norm_req[i] = req[i] && (lvl[i] == LVL_NORMAL);
    end
  endgenerate

  assign top_hit  = top_en && req[top_idx];
  assign high_hit = high_en && req[high_idx] && (lvl[high_idx] == LVL_HIGH);
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int N_CH  = 4,
  localparam int IDX_W = $clog2(N_CH)
) (
  input  logic [N_CH-1:0]  cand,
  input  logic [IDX_W-1:0] last,
  output logic             found,
  output logic [IDX_W-1:0] pick
);
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = N_CH; k >= 1; k--) begin
      logic [IDX_W-1:0] c;
      c = last + IDX_W'(k);
      if (cand[c]) begin
        found = 1'b1;
        pick  = c;
      end
    end
  end
endmodule

// File: rtl/arb_token_count.sv
module arb_token_count #(
  parameter int TOK_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TOK_W-1:0] budget,
  input  logic             consume,
  output logic             final_tok
);
  logic [TOK_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || consume;
    cnt_d  = cnt_q;
    if (load)
      cnt_d = (budget == '0) ? TOK_W'(1) : budget;
    else if (consume && cnt_q > TOK_W'(1))
      cnt_d = cnt_q - TOK_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  assign final_tok = (cnt_q <= TOK_W'(1));
endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter #(
  parameter int N_CH  = 4,
  parameter int TOK_W = 8,
  localparam int IDX_W = $clog2(N_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_CH-1:0]  req,
  input  logic [N_CH-1:0]  cmd_issued,
  input  logic [IDX_W-1:0] top_idx,
  input  logic             top_en,
  input  logic [IDX_W-1:0] high_idx,
  input  logic             high_en,
  input  logic [TOK_W-1:0] tokens,
  output logic [N_CH-1:0]  grant
);
  logic [N_CH-1:0]  grant_q, grant_d;
  logic [IDX_W-1:0] rr_last_q, rr_last_d;
  logic             rr_en;
  logic             top_hit, high_hit;
  logic [N_CH-1:0]  norm_req;
  logic             rr_found;
  logic [IDX_W-1:0] rr_pick;
  logic             idle, tok_load, held_req, held_cmd, final_tok, release_now;

  arb_prio_classify #(.N_CH(N_CH)) u_class (
    .req(req), .top_idx(top_idx), .top_en(top_en),
    .high_idx(high_idx), .high_en(high_en),
    .top_hit(top_hit), .high_hit(high_hit), .norm_req(norm_req)
  );

  arb_rr_pick #(.N_CH(N_CH)) u_rr (
    .cand(norm_req), .last(rr_last_q), .found(rr_found), .pick(rr_pick)
  );

  arb_token_count #(.TOK_W(TOK_W)) u_tok (
    .clk(clk), .rst_n(rst_n), .load(tok_load), .budget(tokens),
    .consume(held_cmd), .final_tok(final_tok)
  );

  assign idle        = (grant_q == '0);
  assign held_req    = |(grant_q & req);
  assign held_cmd    = |(grant_q & cmd_issued);
  assign release_now = !held_req || (held_cmd && final_tok);

  always_comb begin
    grant_d   = grant_q;
    tok_load  = 1'b0;
    rr_en     = 1'b0;
    rr_last_d = rr_last_q;
    if (idle) begin
      if (top_hit) begin
        grant_d  = N_CH'(1) << top_idx;
        tok_load = 1'b1;
      end else if (high_hit) begin
        grant_d  = N_CH'(1) << high_idx;
        tok_load = 1'b1;
      end else if (rr_found) begin
        grant_d   = N_CH'(1) << rr_pick;
        tok_load  = 1'b1;
        rr_en     = 1'b1;
        rr_last_d = rr_pick;
      end
    end else if (release_now) begin
      grant_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      grant_q <= '0;
    else
      grant_q <= grant_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rr_last_q <= IDX_W'(N_CH - 1);
    else if (rr_en)
      rr_last_q <= rr_last_d;
  end

  assign grant = grant_q;
endmodule

// File: rtl/dma_prio_arbiter_chk.sv
module dma_prio_arbiter_chk #(
  parameter int N_CH  = 4,
  parameter int TOK_W = 8,
  localparam int IDX_W = $clog2(N_CH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_CH-1:0]  req,
  input logic [IDX_W-1:0] top_idx,
  input logic             top_en,
  input logic [N_CH-1:0]  grant
);
  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r2_only_requester: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |-> ((grant & ~$past(req)) == '0));

  a_r3_top_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0 && top_en && req[top_idx]) |=> (grant == (N_CH'(1) << $past(top_idx))));

  a_r10_drop_release: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && (grant & req) == '0) |=> (grant == '0));

  a_r11_no_switch: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |=> (grant == '0 || $stable(grant)));
endmodule

bind dma_prio_arbiter dma_prio_arbiter_chk #(.N_CH(N_CH), .TOK_W(TOK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .top_idx(top_idx), .top_en(top_en), .grant(grant)
);

// File: tb/dma_prio_arbiter_test.sv
module dma_prio_arbiter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req = '0;
  logic [3:0] cmd_issued = '0;
  logic [1:0] top_idx = '0;
  logic       top_en = 1'b0;
  logic [1:0] high_idx = '0;
  logic       high_en = 1'b0;
  logic [7:0] tokens = '0;
  logic [3:0] grant;

  int    n_run = 0;
  int    n_fail = 0;
  bit    mon_on = 1'b0;
  string tag = "R2";

  logic [3:0] eg;
  logic [7:0] ecnt;
  int         eptr;

  always #10 clk = ~clk;

  dma_prio_arbiter uut (
    .clk(clk), .rst_n(rst_n), .req(req), .cmd_issued(cmd_issued),
    .top_idx(top_idx), .top_en(top_en), .high_idx(high_idx),
    .high_en(high_en), .tokens(tokens), .grant(grant)
  );

  function automatic bit is_norm(int c);
    if (top_en && int'(top_idx) == c) return 1'b0;
    if (high_en && int'(high_idx) == c) return 1'b0;
    return 1'b1;
  endfunction

  function automatic int pick_win();
    if (top_en && req[top_idx]) return int'(top_idx);
    if (high_en && req[high_idx]) return int'(high_idx);
    for (int k = 1; k <= 4; k++) begin
      int c;
      c = (eptr + k) % 4;
      if (req[c] && is_norm(c)) return c;
    end
    return -1;
  endfunction

  task automatic check(string t, logic [3:0] act, logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s grant=%b expected=%b", t, act, exp);
    end
  endtask

  // reference model, advanced at each rising edge, compared just after
  always @(posedge clk) begin
    if (!rst_n) begin
      eg = '0; ecnt = 8'd0; eptr = 3;
    end else if (eg == '0) begin
      int w;
      w = pick_win();
      if (w >= 0) begin
        eg = 4'(1 << w);
        ecnt = (tokens == 0) ? 8'd1 : tokens;
        if (is_norm(w)) eptr = w;
      end
    end else begin
      if ((eg & req) == '0) eg = '0;                 // R10
      else if ((eg & cmd_issued) != '0) begin        // R8, R9
        if (ecnt <= 8'd1) eg = '0;
        else ecnt = ecnt - 8'd1;
      end
    end
    #1;
    if (mon_on) check(tag, grant, eg);
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #5;
    check("R1 during reset", grant, 4'b0000);
    cyc(2);
    rst_n = 1'b1;
    @(posedge clk); #2;
    check("R1 after reset", grant, 4'b0000);
    @(negedge clk);
    mon_on = 1'b1;

    // R7: all normal, pointer starts so channel 0 comes first
    tag = "R7 rotation";
    tokens = 8'd0;
    req = 4'b1111;
    for (int i = 0; i < 8; i++) begin
      cyc(1);
      cmd_issued = grant;   // R8 tokens 0 acts as 1
      cyc(1);
      cmd_issued = '0;
    end
    req = '0; cyc(3);

    // R8 / R9: budget of 3, stray strobes from other channels
    tag = "R8 R9 tokens";
    tokens = 8'd3;
    req = 4'b0001;
    cyc(2);
    for (int i = 0; i < 6; i++) begin
      cmd_issued = 4'b1110;  cyc(1);   // ignored
      cmd_issued = 4'b0001;  cyc(1);
      cmd_issued = '0;       cyc(1);
    end
    req = '0; cyc(3);

    // R10: dropped request releases at once
    tag = "R10 drop";
    tokens = 8'd50;
    req = 4'b0100; cyc(3);
    req = 4'b0000; cyc(3);

    // R3 R4 R5 R6 R11: sweep every slot setting against every pattern
    tokens = 8'd2;
    for (int cfg = 0; cfg < 64; cfg++) begin
      top_en = cfg[0]; top_idx = 2'(cfg >> 1);
      high_en = cfg[3]; high_idx = 2'(cfg >> 4);
      if (top_en && high_en && top_idx == high_idx) tag = "R5 shared slot";
      else if (!top_en || !high_en) tag = "R6 disabled slot";
      else tag = "R3 R4 R11 levels";
      for (int p = 1; p < 16; p++) begin
        req = 4'(p);
        cyc(1);
        cmd_issued = 4'b1111; cyc(1);
        cmd_issued = 4'b0000; cyc(1);
        cmd_issued = 4'b1111; cyc(1);
        cmd_issued = 4'b0000;
        req = 4'(p ^ 4'b0101); cyc(2);
        req = '0; cyc(2);
      end
    end

    mon_on = 1'b0;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_run++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule